// File: doc/BRIEF.md
# Debug Register Move Unit

This block executes the two privileged instructions that copy a 32-bit value between a bank of eight debug-register slots and the general-purpose register file. The front end presents one instruction at a time: the opcode byte that follows the two-byte escape, the operand selector byte, the current privilege level, a real-mode indicator, and the debug-extension control bit. The unit decodes the selector, checks privilege and encoding, and then runs the access for a fixed number of cycles that depends on the direction and on the slot. The result is either a done strobe with the register update or a single fault pulse.

Slot selection takes the middle three bits of the selector byte. The low three bits name the general-purpose register. This index is driven straight out as the register-file read address for stores and is returned with the data for loads. The two top bits of the selector are ignored. Slots 4 and 5 behave in one of two ways, chosen by the debug-extension bit. When the bit is clear, they are folded onto slots 6 and 7. When the bit is set, they are illegal encodings and raise a fault.

Top module: `dbg_move_unit`

## Requirements
- R1: With `opcode` = 8'h21, the resolved slot's value appears on `gpr_wdata` with `gpr_we` high and `gpr_widx` = `sel_byte[2:0]`, all in the same cycle as `done`.
- R2: With `opcode` = 8'h23, the value on `gpr_rdata` in the cycle `start` is accepted is written into the resolved slot. The new value is visible on `dbg_regs` in the `done` cycle, and `gpr_we` stays low.
- R3: `sel_byte[5:3]` selects the slot and `sel_byte[2:0]` is driven combinationally onto `gpr_ridx`. The values of `sel_byte[7:6]` change nothing. Slot n occupies `dbg_regs[n*32 +: 32]`.
- R4: With `dbg_ext_en` = 0, selector slot 4 accesses slot 6 and selector slot 5 accesses slot 7. Slots 4 and 5 of the storage are never written.
- R5: With `dbg_ext_en` = 1, a selector slot of 4 or 5 gives a one-cycle `undef_fault` in the cycle after acceptance. No register is written and no `done` follows. Slots 6 and 7 remain reachable directly.
- R6: When `cpl` is not 0 and `real_mode` = 0, the instruction gives a one-cycle `prot_fault` in the cycle after acceptance and writes nothing. This check takes priority over the R5 check. With `real_mode` = 1, any `cpl` is allowed.
- R7: Any opcode other than 8'h21 or 8'h23 gives `undef_fault` and writes nothing.
- R8: `done` rises exactly L cycles after the clock edge that accepts `start`. L depends on the resolved slot: a load from slots 0 to 3 takes 2, a load from slots 6 and 7 takes 12, a store to slots 0 to 3 takes 11, and a store to slots 6 and 7 takes 12.
- R9: `done`, `undef_fault` and `prot_fault` are each one-cycle pulses, and at most one of them is high in any cycle. `flags_undef`, which marks the six arithmetic flags as undefined, is high exactly in the `done` cycle.
- R10: While `busy` is high, `start` is ignored: it launches no access and changes no register.
- R11: Reset clears all eight slots to zero, and `busy`, `done`, both faults and `gpr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe for one instruction |
| opcode | input | 8 | Opcode byte after the escape byte |
| sel_byte | input | 8 | Operand selector: [5:3] slot, [2:0] register |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Real-address mode indicator |
| dbg_ext_en | input | 1 | Debug-extension control bit |
| gpr_ridx | output | 3 | Register-file read address |
| gpr_rdata | input | 32 | Register-file read data |
| gpr_we | output | 1 | Register-file write enable |
| gpr_widx | output | 3 | Register-file write address |
| gpr_wdata | output | 32 | Register-file write data |
| dbg_regs | output | 256 | Contents of the eight slots, slot n at [n*32 +: 32] |
| busy | output | 1 | An access is in flight |
| done | output | 1 | Completion pulse |
| flags_undef | output | 1 | Arithmetic flags undefined, with done |
| undef_fault | output | 1 | Undefined-opcode fault pulse |
| prot_fault | output | 1 | Protection fault pulse |

## Verification
The bench loads and reads back through both alias slots with the extension bit clear. A design that failed to fold them would store into slots 4 or 5 and read zeros back. With the bit set, the bench aims the same selectors at a trap and also reads slot 6 directly, which catches a decoder that blocks the whole upper half. It pairs an illegal slot with a privilege violation to pin the fault priority, and it counts the cycles to `done` for each direction and each latency class. A second `start` issued mid-flight has to leave its target slot unchanged, and a design that queued it or overwrote the active access would show either an extra `done` or the wrong slot value.

// File: rtl/dbg_move_pkg.sv
package dbg_move_pkg;

  localparam logic [7:0] OPC_TO_GPR = 8'h21;
  localparam logic [7:0] OPC_TO_DBG = 8'h23;

  typedef enum logic [1:0] {
    CHK_OK    = 2'd0,
    CHK_UNDEF = 2'd1,
    CHK_PROT  = 2'd2
  } chk_e;

  typedef struct packed {
    logic       is_store;
    logic [2:0] slot;
    logic [2:0] gidx;
  } mv_op_t;

endpackage

// File: rtl/dbg_move_decode.sv
module dbg_move_decode
  import dbg_move_pkg::*;
#(
  parameter int RD_FAST = 2,
  parameter int RD_SLOW = 12,
  parameter int WR_FAST = 11,
  parameter int WR_SLOW = 12,
  parameter int LAT_W   = 4
) (
  input  logic [7:0]       opcode,
  input  logic [5:0]       sel_lo,
  input  logic [1:0]       cpl,
  input  logic             real_mode,
  input  logic             dbg_ext_en,
  output chk_e             chk,
  output mv_op_t           op,
  output logic [LAT_W-1:0] lat
);

  logic [2:0] raw_slot;
  logic       known_op;
  logic       priv_ok;
  logic       in_alias;
  logic       slow_slot;

  always_comb begin
    raw_slot  = sel_lo[5:3];
    known_op  = (opcode == OPC_TO_GPR) || (opcode == OPC_TO_DBG);
    priv_ok   = real_mode || (cpl == 2'd0);
    in_alias  = (raw_slot == 3'd4) || (raw_slot == 3'd5);

    op.is_store = (opcode == OPC_TO_DBG);
    op.slot     = in_alias ? {2'b11, raw_slot[0]} : raw_slot;
    op.gidx     = sel_lo[2:0];

    if (!known_op)                 chk = CHK_UNDEF;
    else if (!priv_ok)             chk = CHK_PROT;
    else if (in_alias && dbg_ext_en) chk = CHK_UNDEF;
    else                           chk = CHK_OK;

    slow_slot = op.slot[2];
    if (op.is_store) lat = slow_slot ? LAT_W'(WR_SLOW) : LAT_W'(WR_FAST);
    else             lat = slow_slot ? LAT_W'(RD_SLOW) : LAT_W'(RD_FAST);
  end

endmodule

// File: rtl/dbg_move_store.sv
module dbg_move_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int SLOTS = 1 << IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IDX_W-1:0]        ridx,
  output logic [DATA_W-1:0]       rdata,
  output logic [SLOTS*DATA_W-1:0] flat
);

  logic [DATA_W-1:0] mem_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= wdata;
    end

    assign flat[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign rdata = mem_q[ridx];

  AST_NO_ALIAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx != IDX_W'(4) && widx != IDX_W'(5))); // R4

endmodule

// File: rtl/dbg_move_seq.sv
module dbg_move_seq
  import dbg_move_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  chk_e              chk,
  input  mv_op_t            op,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] gpr_rdata,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic [2:0]        slot_ridx,
  output logic              store_we,
  output logic [2:0]        store_widx,
  output logic [DATA_W-1:0] store_wdata,
  output logic              gpr_we,
  output logic [2:0]        gpr_widx,
  output logic [DATA_W-1:0] gpr_wdata,
  output logic              busy,
  output logic              done,
  output logic              undef_fault,
  output logic              prot_fault
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

  st_e               state_q, state_d;
  logic [LAT_W-1:0]  cnt_q, cnt_d;
  mv_op_t            op_q, op_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              undef_q, undef_d;
  logic              prot_q, prot_d;
  logic              gwe_q, gwe_d;
  logic [2:0]        gidx_q, gidx_d;
  logic [DATA_W-1:0] gdata_q, gdata_d;
  logic              last_cyc;

  assign last_cyc = (state_q == ST_RUN) && (cnt_q == LAT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    data_d  = data_q;
    done_d  = 1'b0;
    undef_d = 1'b0;
    prot_d  = 1'b0;
    gwe_d   = 1'b0;
    gidx_d  = gidx_q;
    gdata_d = gdata_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          case (chk)
            CHK_OK: begin
              state_d = ST_RUN;
              cnt_d   = lat;
              op_d    = op;
              data_d  = gpr_rdata;
            end
            CHK_UNDEF: undef_d = 1'b1;
            default:   prot_d  = 1'b1;
          endcase
        end
      end
      default: begin
        cnt_d = cnt_q - LAT_W'(1);
        if (last_cyc) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (!op_q.is_store) begin
            gwe_d   = 1'b1;
            gidx_d  = op_q.gidx;
            gdata_d = slot_rdata;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      prot_q  <= 1'b0;
      gwe_q   <= 1'b0;
      gidx_q  <= '0;
      gdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      data_q  <= data_d;
      done_q  <= done_d;
      undef_q <= undef_d;
      prot_q  <= prot_d;
      gwe_q   <= gwe_d;
      gidx_q  <= gidx_d;
      gdata_q <= gdata_d;
    end
  end

  assign slot_ridx   = op_q.slot;
  assign store_we    = last_cyc && op_q.is_store;
  assign store_widx  = op_q.slot;
  assign store_wdata = data_q;
  assign gpr_we      = gwe_q;
  assign gpr_widx    = gidx_q;
  assign gpr_wdata   = gdata_q;
  assign busy        = (state_q == ST_RUN);
  assign done        = done_q;
  assign undef_fault = undef_q;
  assign prot_fault  = prot_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, undef_q, prot_q})); // R9
  AST_GPR_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    gwe_q |-> done_q); // R1
  AST_STORE_NO_GPR_WE: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |=> !gwe_q); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cyc) |=> (busy && cnt_q == $past(cnt_q) - LAT_W'(1))); // R10

endmodule

// File: rtl/dbg_move_unit.sv
module dbg_move_unit
  import dbg_move_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RD_FAST = 2,
  parameter int RD_SLOW = 12,
  parameter int WR_FAST = 11,
  parameter int WR_SLOW = 12,
  localparam int IDX_W  = 3,
  localparam int SLOTS  = 1 << IDX_W,
  localparam int LAT_MAX_RD = (RD_FAST > RD_SLOW) ? RD_FAST : RD_SLOW,
  localparam int LAT_MAX_WR = (WR_FAST > WR_SLOW) ? WR_FAST : WR_SLOW,
  localparam int LAT_MAX = (LAT_MAX_RD > LAT_MAX_WR) ? LAT_MAX_RD : LAT_MAX_WR,
  localparam int LAT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              opcode,
  input  logic [7:0]              sel_byte,
  input  logic [1:0]              cpl,
  input  logic                    real_mode,
  input  logic                    dbg_ext_en,
  output logic [IDX_W-1:0]        gpr_ridx,
  input  logic [DATA_W-1:0]       gpr_rdata,
  output logic                    gpr_we,
  output logic [IDX_W-1:0]        gpr_widx,
  output logic [DATA_W-1:0]       gpr_wdata,
  output logic [SLOTS*DATA_W-1:0] dbg_regs,
  output logic                    busy,
  output logic                    done,
  output logic                    flags_undef,
  output logic                    undef_fault,
  output logic                    prot_fault
);

  chk_e              chk;
  mv_op_t            op;
  logic [LAT_W-1:0]  lat;
  logic [2:0]        slot_ridx;
  logic [DATA_W-1:0] slot_rdata;
  logic              store_we;
  logic [2:0]        store_widx;
  logic [DATA_W-1:0] store_wdata;

  assign gpr_ridx = sel_byte[2:0];

  dbg_move_decode #(
    .RD_FAST(RD_FAST), .RD_SLOW(RD_SLOW),
    .WR_FAST(WR_FAST), .WR_SLOW(WR_SLOW), .LAT_W(LAT_W)
  ) u_decode (
    .opcode     (opcode),
    .sel_lo     (sel_byte[5:0]),
    .cpl        (cpl),
    .real_mode  (real_mode),
    .dbg_ext_en (dbg_ext_en),
    .chk        (chk),
    .op         (op),
    .lat        (lat)
  );

  dbg_move_seq #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chk         (chk),
    .op          (op),
    .lat         (lat),
    .gpr_rdata   (gpr_rdata),
    .slot_rdata  (slot_rdata),
    .slot_ridx   (slot_ridx),
    .store_we    (store_we),
    .store_widx  (store_widx),
    .store_wdata (store_wdata),
    .gpr_we      (gpr_we),
    .gpr_widx    (gpr_widx),
    .gpr_wdata   (gpr_wdata),
    .busy        (busy),
    .done        (done),
    .undef_fault (undef_fault),
    .prot_fault  (prot_fault)
  );

  dbg_move_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .widx  (store_widx),
    .wdata (store_wdata),
    .ridx  (slot_ridx),
    .rdata (slot_rdata),
    .flat  (dbg_regs)
  );

  assign flags_undef = done;

  AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_fault || prot_fault) |-> $stable(dbg_regs)); // R5
  AST_MOD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && chk == CHK_OK && sel_byte[7:6] != 2'b11) |=> busy); // R3
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_undef |-> !undef_fault && !prot_fault); // R9

endmodule

// File: tb/dbg_move_unit_test.sv
module dbg_move_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [7:0]   opcode;
  logic [7:0]   sel_byte;
  logic [1:0]   cpl;
  logic         real_mode;
  logic         dbg_ext_en;
  logic [2:0]   gpr_ridx;
  logic [31:0]  gpr_rdata;
  logic         gpr_we;
  logic [2:0]   gpr_widx;
  logic [31:0]  gpr_wdata;
  logic [255:0] dbg_regs;
  logic         busy, done, flags_undef, undef_fault, prot_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] shadow [8];

  always #5 clk = ~clk;

  dbg_move_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .sel_byte(sel_byte),
    .cpl(cpl), .real_mode(real_mode), .dbg_ext_en(dbg_ext_en), .gpr_ridx(gpr_ridx),
    .gpr_rdata(gpr_rdata), .gpr_we(gpr_we), .gpr_widx(gpr_widx), .gpr_wdata(gpr_wdata),
    .dbg_regs(dbg_regs), .busy(busy), .done(done), .flags_undef(flags_undef),
    .undef_fault(undef_fault), .prot_fault(prot_fault)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  sel;
    logic [1:0]  cpl;
    logic        rm;
    logic        ext;
    logic [31:0] data;
    logic [1:0]  kind;   // 0 done, 1 undefined fault, 2 protection fault
    logic [4:0]  lat;
    logic [2:0]  slot;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h23, 8'hC1, 2'd0, 1'b0, 1'b0, 32'h1111_1111, 2'd0, 5'd11, 3'd0, 32'h0,          4'd2}, // R2 store slot 0
    '{8'h23, 8'h1A, 2'd0, 1'b0, 1'b0, 32'h3333_3333, 2'd0, 5'd11, 3'd3, 32'h0,          4'd3}, // R3 top bits 00
    '{8'h23, 8'hF3, 2'd0, 1'b0, 1'b0, 32'h6666_6666, 2'd0, 5'd12, 3'd6, 32'h0,          4'd8}, // R8 slow store
    '{8'h23, 8'hEC, 2'd0, 1'b0, 1'b0, 32'h7777_7777, 2'd0, 5'd12, 3'd7, 32'h0,          4'd4}, // R4 5 -> 7
    '{8'h21, 8'hC2, 2'd0, 1'b0, 1'b0, 32'h0,         2'd0, 5'd2,  3'd0, 32'h1111_1111, 4'd1}, // R1 fast load
    '{8'h21, 8'hE5, 2'd0, 1'b0, 1'b0, 32'h0,         2'd0, 5'd12, 3'd6, 32'h6666_6666, 4'd4}, // R4 4 -> 6
    '{8'h21, 8'hDF, 2'd0, 1'b0, 1'b0, 32'h0,         2'd0, 5'd2,  3'd3, 32'h3333_3333, 4'd1}, // R1 load slot 3
    '{8'h23, 8'hE0, 2'd0, 1'b0, 1'b1, 32'hDEAD_BEEF, 2'd1, 5'd0,  3'd0, 32'h0,          4'd5}, // R5 store 4 trapped
    '{8'h21, 8'hE9, 2'd0, 1'b0, 1'b1, 32'h0,         2'd1, 5'd0,  3'd0, 32'h0,          4'd5}, // R5 load 5 trapped
    '{8'h23, 8'hC8, 2'd3, 1'b0, 1'b0, 32'hBAD0_0001, 2'd2, 5'd0,  3'd0, 32'h0,          4'd6}, // R6 level 3
    '{8'h23, 8'hC8, 2'd3, 1'b1, 1'b0, 32'hAAAA_5555, 2'd0, 5'd11, 3'd1, 32'h0,          4'd6}, // R6 real mode
    '{8'h21, 8'hE0, 2'd2, 1'b0, 1'b1, 32'h0,         2'd2, 5'd0,  3'd0, 32'h0,          4'd6}, // R6 priority
    '{8'h22, 8'hC0, 2'd0, 1'b0, 1'b0, 32'hBAD0_0002, 2'd1, 5'd0,  3'd0, 32'h0,          4'd7}, // R7 bad opcode
    '{8'h21, 8'hFE, 2'd0, 1'b0, 1'b0, 32'h0,         2'd0, 5'd12, 3'd7, 32'h7777_7777, 4'd8}, // R8 slow load
    '{8'h21, 8'hF1, 2'd0, 1'b0, 1'b1, 32'h0,         2'd0, 5'd12, 3'd6, 32'h6666_6666, 4'd5}, // R5 direct slot 6
    '{8'h23, 8'h50, 2'd0, 1'b0, 1'b0, 32'h2222_2222, 2'd0, 5'd11, 3'd2, 32'h0,          4'd3}, // R3 top bits 01
    '{8'h21, 8'hC8, 2'd1, 1'b1, 1'b0, 32'h0,         2'd0, 5'd2,  3'd1, 32'hAAAA_5555, 4'd6}  // R6 real load
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int s = 0; s < 8; s++)
      check($sformatf("%s slot %0d", tag, s), dbg_regs[s*32 +: 32], shadow[s]);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int cyc;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    opcode = v.op; sel_byte = v.sel; cpl = v.cpl; real_mode = v.rm;
    dbg_ext_en = v.ext; gpr_rdata = v.data; start = 1'b1;
    check({tag, " R3 read index"}, 32'(gpr_ridx), 32'(v.sel[2:0]));
    @(negedge clk);
    start = 1'b0;
    gpr_rdata = 32'hFFFF_0000;
    if (v.kind != 2'd0) begin
      check({tag, " undef_fault"}, 32'(undef_fault), 32'(v.kind == 2'd1));
      check({tag, " prot_fault"}, 32'(prot_fault), 32'(v.kind == 2'd2));
      check({tag, " busy after fault"}, 32'(busy), 32'h0);
      @(negedge clk);
      check({tag, " R9 fault pulse width"}, 32'({undef_fault, prot_fault}), 32'h0);
    end else begin
      check({tag, " no fault"}, 32'({undef_fault, prot_fault}), 32'h0);
      wait_done(cyc);
      check({tag, " R8 latency"}, 32'(cyc), 32'(v.lat));
      check({tag, " R9 flags_undef"}, 32'(flags_undef), 32'h1);
      if (v.op == 8'h21) begin
        check({tag, " R1 gpr_we"}, 32'(gpr_we), 32'h1);
        check({tag, " R1 gpr_wdata"}, gpr_wdata, v.val);
        check({tag, " R1 gpr_widx"}, 32'(gpr_widx), 32'(v.sel[2:0]));
      end else begin
        check({tag, " R2 no gpr_we"}, 32'(gpr_we), 32'h0);
        shadow[v.slot] = v.data;
      end
      check_regs({tag, " at done"});
      @(negedge clk);
      check({tag, " R9 done pulse width"}, 32'({done, flags_undef, gpr_we}), 32'h0);
    end
    check_regs({tag, " after"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    int extra;
    rst_n = 1'b0; start = 1'b0; opcode = '0; sel_byte = '0; cpl = '0;
    real_mode = 1'b0; dbg_ext_en = 1'b0; gpr_rdata = '0;
    for (int s = 0; s < 8; s++) shadow[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_regs("R11 reset");
    check("R11 outputs", 32'({busy, done, undef_fault, prot_fault, gpr_we}), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 start while busy is ignored
    @(negedge clk);
    opcode = 8'h23; sel_byte = 8'hC0; cpl = 2'd0; real_mode = 1'b0;
    dbg_ext_en = 1'b0; gpr_rdata = 32'hDEAD_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy", 32'(busy), 32'h1);
    @(negedge clk);
    opcode = 8'h23; sel_byte = 8'hD8; gpr_rdata = 32'h0BAD_0BAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check("R10 first access latency", 32'(cyc + 2), 32'd11);
    shadow[0] = 32'hDEAD_0000;
    check_regs("R10 at done");
    extra = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check("R10 no second access", 32'(extra), 32'h0);
    check_regs("R10 after");

    // R11 reset clears written slots
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) shadow[s] = '0;
    @(negedge clk);
    check_regs("R11 second reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule